// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

This block adds two unsigned 16-bit operands and a carry-in. It returns a 16-bit sum and a carry-out. It has no clock and no state, so every output follows its inputs within the same cycle.

The carries are not passed along bit by bit. The operand bits are split into four 4-bit groups, and each group has its own lookahead carry unit, which computes every carry inside the group at once. A fifth lookahead unit, one level up, takes the group-level propagate and generate pairs and forms the carry into each of the upper three groups. The block also outputs its own 16-bit propagate and generate terms. An adder four times as wide can therefore be built from four of these blocks and one more lookahead unit of the same kind.

The group width and the group count are parameters. Their defaults give the 16-bit adder described here.

Top module: `cla_adder16`

## Requirements
- R1: `sum_o` equals the low 16 bits of `a_i + b_i + cin_i`, taken as unsigned values, for every operand value from 0 to 65535.
- R2: `cout_o` equals bit 16 of the 17-bit value `a_i + b_i + cin_i`.
- R3: `prop_o` is 1 exactly when `a_i` and `b_i` differ in every one of the 16 bit positions, that is, when `a_i ^ b_i` is 0xFFFF.
- R4: `gen_o` is 1 exactly when `a_i + b_i` with no carry-in is 65536 or more.
- R5: `cout_o` always equals `gen_o | (prop_o & cin_i)`.
- R6: The carry into each bit and each group matches the ripple relation `c[i+1] = g[i] | (p[i] & c[i])`. At the ports this means:
  - with `a_i ^ b_i` at 0xFFFF and `cin_i` at 1, the carry runs through all 16 bits, giving `sum_o` 0 and `cout_o` 1;
  - with `cin_i` at 0 on the same operands, `sum_o` is 0xFFFF and `cout_o` is 0.
- R7: `prop_o` and `gen_o` are never both 1, because the per-bit propagate is the XOR of the operand bits.
- R8: The block is purely combinational. A change on any input shows on the outputs before the next clock edge, and no earlier input values have any effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 16 | First unsigned operand |
| b_i | input | 16 | Second unsigned operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | 16 | Low 16 bits of the sum |
| cout_o | output | 1 | Carry out of bit 15 |
| prop_o | output | 1 | Block propagate, used to chain wider adders |
| gen_o | output | 1 | Block generate, used to chain wider adders |

## Verification
The assertions are evaluated every time the inputs change:
- **Carry relation (R6):** each lookahead unit's carries are checked against the bit-by-bit carry relation.
- **Exclusive P and G (R7):** each group's propagate and generate, and the block's pair, are checked never to be 1 together.
- **Carry-out (R5):** the carry-out is checked against the block propagate and generate.
- **Sum (R1):** the full 17-bit result is checked against the arithmetic sum.

The bench covers what only directed stimulus can show:
- the all-zero and all-ones extremes;
- alternating bit patterns;
- a carry entering at each bit position and running to the top;
- that nothing is remembered from the previous operands, by switching between very different values back to back (R8).

// File: rtl/cla_pkg.sv
package cla_pkg;

  localparam int unsigned CLA_MAX_W = 32;

  typedef logic [CLA_MAX_W-1:0] cla_vec_t;

  // Sum-of-products carry into position k, flattened (no ripple chain).
  function automatic logic la_carry(input cla_vec_t p, input cla_vec_t g,
                                    input logic cin, input int unsigned k);
    logic acc;
    logic term;
    acc = 1'b0;
    for (int j = 0; j < CLA_MAX_W; j++) begin
      if (j < k) begin
        term = g[j];
        for (int m = 0; m < CLA_MAX_W; m++) begin
          if (m > j && m < k) term = term & p[m];
        end
        acc = acc | term;
      end
    end
    term = cin;
    for (int m = 0; m < CLA_MAX_W; m++) begin
      if (m < k) term = term & p[m];
    end
    return acc | term;
  endfunction

  // Block propagate over the low n positions.
  function automatic logic la_prop(input cla_vec_t p, input int unsigned n);
    logic acc;
    acc = 1'b1;
    for (int m = 0; m < CLA_MAX_W; m++) begin
      if (m < n) acc = acc & p[m];
    end
    return acc;
  endfunction

  // Block generate over the low n positions.
  function automatic logic la_gen(input cla_vec_t p, input cla_vec_t g,
                                  input int unsigned n);
    return la_carry(p, g, 1'b0, n);
  endfunction

  function automatic logic carry_out(input logic gen, input logic prop,
                                     input logic cin);
    return gen | (prop & cin);
  endfunction

endpackage

// File: rtl/cla_lookahead.sv
module cla_lookahead
  import cla_pkg::*;
#(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] p_i,
  input  logic [N-1:0] g_i,
  input  logic         c_i,
  output logic [N-1:0] carry_o,
  output logic         prop_o,
  output logic         gen_o
);

  cla_vec_t p_ext;
  cla_vec_t g_ext;

  always_comb begin
    p_ext = '0;
    g_ext = '0;
    p_ext[N-1:0] = p_i;
    g_ext[N-1:0] = g_i;
  end

  genvar k;
  generate
    for (k = 0; k < N; k++) begin : g_carry
      assign carry_o[k] = la_carry(p_ext, g_ext, c_i, k);
    end
  endgenerate

  assign prop_o = la_prop(p_ext, N);
  assign gen_o  = la_gen(p_ext, g_ext, N);

  // Ripple relation between neighbouring lookahead carries.
  always_comb begin
    AST_CARRY_ZERO: assert (carry_o[0] == c_i) else $error("carry0 mismatch"); // R6
    for (int i = 0; i + 1 < N; i++) begin
      AST_CARRY_CHAIN: assert (carry_o[i+1] == (g_i[i] | (p_i[i] & carry_o[i])))
        else $error("lookahead carry %0d mismatch", i + 1); // R6
    end
    AST_GROUP_COUT: assert (carry_out(gen_o, prop_o, c_i) ==
                            (g_i[N-1] | (p_i[N-1] & carry_o[N-1])))
      else $error("group carry-out mismatch"); // R5
  end

endmodule

// File: rtl/cla_group.sv
module cla_group
  import cla_pkg::*;
#(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         c_i,
  output logic [W-1:0] sum_o,
  output logic         prop_o,
  output logic         gen_o
);

  logic [W-1:0] bit_p;
  logic [W-1:0] bit_g;
  logic [W-1:0] bit_c;

  assign bit_p = a_i ^ b_i;
  assign bit_g = a_i & b_i;

  cla_lookahead #(.N(W)) u_lcu (
    .p_i    (bit_p),
    .g_i    (bit_g),
    .c_i    (c_i),
    .carry_o(bit_c),
    .prop_o (prop_o),
    .gen_o  (gen_o)
  );

  assign sum_o = bit_p ^ bit_c;

  always_comb begin
    AST_GROUP_EXCL: assert (!(prop_o && gen_o))
      else $error("group P and G both set"); // R7
    AST_GROUP_SUM: assert ({carry_out(gen_o, prop_o, c_i), sum_o} ==
                           ({1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, c_i}))
      else $error("group sum mismatch"); // R1
  end

endmodule

// File: rtl/cla_adder16.sv
module cla_adder16
  import cla_pkg::*;
#(
  parameter  int unsigned GROUP_W    = 4,
  parameter  int unsigned NUM_GROUPS = 4,
  localparam int unsigned DATA_W     = GROUP_W * NUM_GROUPS
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              cin_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              cout_o,
  output logic              prop_o,
  output logic              gen_o
);

  logic [NUM_GROUPS-1:0] grp_p;
  logic [NUM_GROUPS-1:0] grp_g;
  logic [NUM_GROUPS-1:0] grp_c;

  genvar k;
  generate
    for (k = 0; k < NUM_GROUPS; k++) begin : g_grp
      cla_group #(.W(GROUP_W)) u_grp (
        .a_i   (a_i[k*GROUP_W +: GROUP_W]),
        .b_i   (b_i[k*GROUP_W +: GROUP_W]),
        .c_i   (grp_c[k]),
        .sum_o (sum_o[k*GROUP_W +: GROUP_W]),
        .prop_o(grp_p[k]),
        .gen_o (grp_g[k])
      );
    end
  endgenerate

  // Second level: carries into each group from group P/G pairs.
  cla_lookahead #(.N(NUM_GROUPS)) u_top_lcu (
    .p_i    (grp_p),
    .g_i    (grp_g),
    .c_i    (cin_i),
    .carry_o(grp_c),
    .prop_o (prop_o),
    .gen_o  (gen_o)
  );

  assign cout_o = carry_out(gen_o, prop_o, cin_i);

  always_comb begin
    AST_FULL_SUM: assert ({cout_o, sum_o} ==
                          ({1'b0, a_i} + {1'b0, b_i} + {{DATA_W{1'b0}}, cin_i}))
      else $error("sum mismatch"); // R1
    AST_BLOCK_PROP: assert (prop_o == (&(a_i ^ b_i)))
      else $error("block propagate mismatch"); // R3
    AST_BLOCK_EXCL: assert (!(prop_o && gen_o))
      else $error("block P and G both set"); // R7
  end

endmodule

// File: tb/tb_cla_adder16.sv
module tb_cla_adder16;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic [W-1:0] a, b;
  logic         cin;
  logic [W-1:0] sum;
  logic         cout, prop, gen;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  logic [31:0] lfsr = 32'hACE1_2468;

  always #10 clk = ~clk;

  cla_adder16 dut (
    .a_i(a), .b_i(b), .cin_i(cin),
    .sum_o(sum), .cout_o(cout), .prop_o(prop), .gen_o(gen)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s a=%h b=%h cin=%0d actual=%h expected=%h",
               req, what, a, b, cin, act, exp);
    end
  endtask

  // Drive on a rising edge, sample on the following falling edge.
  task automatic apply_and_check(input logic [W-1:0] av, input logic [W-1:0] bv,
                                 input logic cv);
    logic [W:0] full;
    logic [W:0] nocin;
    @(posedge clk);
    a = av; b = bv; cin = cv;
    @(negedge clk);
    full  = {1'b0, av} + {1'b0, bv} + {{W{1'b0}}, cv};
    nocin = {1'b0, av} + {1'b0, bv};
    chk("R1", "sum",  {16'h0, sum},  {16'h0, full[W-1:0]});
    chk("R2", "cout", {31'h0, cout}, {31'h0, full[W]});
    chk("R3", "prop", {31'h0, prop}, {31'h0, ((av ^ bv) == 16'hFFFF)});
    chk("R4", "gen",  {31'h0, gen},  {31'h0, nocin[W]});
    chk("R5", "cout_vs_pg", {31'h0, cout}, {31'h0, gen | (prop & cv)});
    chk("R7", "pg_excl", {31'h0, prop & gen}, 32'h0);
  endtask

  task automatic t_zero_state;
    apply_and_check(16'h0000, 16'h0000, 1'b0);
    chk("R1", "zero_sum", {16'h0, sum}, 32'h0);
  endtask

  task automatic t_extremes;
    apply_and_check(16'hFFFF, 16'hFFFF, 1'b0);
    apply_and_check(16'hFFFF, 16'hFFFF, 1'b1);
    apply_and_check(16'hFFFF, 16'h0001, 1'b0);
    apply_and_check(16'hFFFF, 16'h0000, 1'b1);
    apply_and_check(16'h0000, 16'h0000, 1'b1);
    apply_and_check(16'h8000, 16'h8000, 1'b0);
  endtask

  task automatic t_alternating;
    apply_and_check(16'hAAAA, 16'h5555, 1'b0);
    apply_and_check(16'hAAAA, 16'h5555, 1'b1);
    apply_and_check(16'hAAAA, 16'hAAAA, 1'b1);
    apply_and_check(16'h5555, 16'h5555, 1'b0);
    apply_and_check(16'hF0F0, 16'h0F0F, 1'b1);
    apply_and_check(16'hCCCC, 16'h3333, 1'b0);
  endtask

  // R6: full-length propagate chain, and a carry entering at every position.
  task automatic t_chain;
    apply_and_check(16'h1234, 16'hEDCB, 1'b1);
    chk("R6", "chain_sum",  {16'h0, sum},  32'h0);
    chk("R6", "chain_cout", {31'h0, cout}, 32'h1);
    apply_and_check(16'h1234, 16'hEDCB, 1'b0);
    chk("R6", "nochain_sum",  {16'h0, sum},  32'hFFFF);
    chk("R6", "nochain_cout", {31'h0, cout}, 32'h0);
    for (int k = 0; k < W; k++) begin
      logic [W-1:0] av;
      logic [W-1:0] bv;
      av = 16'h1 << k;
      bv = 16'hFFFF << k;
      apply_and_check(av, bv, 1'b0);
      chk("R6", "insert_sum", {16'h0, sum}, 32'h0);
      apply_and_check(16'hFFFF >> (W - 1 - k), 16'h0000, 1'b1);
    end
  endtask

  // R8: no memory of earlier operands; outputs follow within the cycle.
  task automatic t_no_memory;
    apply_and_check(16'hFFFF, 16'hFFFF, 1'b1);
    apply_and_check(16'h0003, 16'h0004, 1'b0);
    chk("R8", "after_big", {15'h0, cout, sum}, 32'h7);
    apply_and_check(16'h0000, 16'h0000, 1'b0);
    chk("R8", "back_to_zero", {14'h0, prop, gen, cout, sum}, 32'h0);
  endtask

  task automatic t_random;
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      apply_and_check(lfsr[15:0], lfsr[31:16] ^ {lfsr[7:0], lfsr[15:8]},
                      lfsr[5]);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    a = '0; b = '0; cin = 1'b0;
    t_zero_state();
    t_extremes();
    t_alternating();
    t_chain();
    t_no_memory();
    t_random();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule